// File: doc/BRIEF.md
# Powered-Port Signature Probe Sequencer

This block runs one Ethernet port through the signature-detection step that comes before any power is applied. Detection starts when the enable input goes high. The block keeps the port's power switch open and commands an external probe source to two test levels, one after the other. At each level it first lets the line settle for a programmed number of timebase ticks. It then sums a fixed, power-of-two number of voltage and current samples from an ADC sample stream. This long integration window averages out mains hum at 50 Hz and 60 Hz. The block divides each sum by shifting it, and presents the two (voltage, current) averages to a downstream classifier, which computes the slope.

The classifier answers with a pass or fail verdict. On a pass the block reports a good signature and holds that result until the enable input goes low. On a fail with midspan mode off, the block stops and reports the failure. In midspan mode a fail starts a back-off wait, and a new attempt begins when the wait ends. The first attempt after enable always starts at once, with no back-off. Dropping the enable input ends the cycle from any state.

All durations are counted in ticks of a timebase input. The tick counts and sample count are parameters, so a short simulation can use reduced values.

Top module: `poe_probe_seq`

## Requirements
- R1: `pwr_on` is 0 at all times, in reset and in every state of the detection cycle.
- R2: When `det_en` is high in idle, the next clock edge starts the first probe level. `probe_code` shows `CODE_LO` in the following cycle, with no back-off, including after an abort.
- R3: Within an attempt, `probe_code` is `CODE_LO` (default 40) for the first point and then `CODE_HI` (default 90) for the second. It is 0 whenever no probe level is active.
- R4: After each probe-level change, the block waits exactly `SETTLE_TICKS` ticks before it accepts any sample. Samples offered during settling do not enter the averages.
- R5: Each point sums 2^`LOG2_N` samples, counting only cycles where `smp_valid` is high. The reported average is the sum shifted right by `LOG2_N`, and it stays exact when every sample is at full scale.
- R6: In the cycle after the last sample of the second point, `meas_valid` pulses for exactly one cycle. At that time `v_lo`/`i_lo` hold the first-point averages and `v_hi`/`i_hi` hold the second-point averages.
- R7: A pass verdict (`verdict_valid` with `verdict_pass`=1) sets `det_done` and `det_good`. Both stay high while `det_en` stays high, and no new probing starts.
- R8: A fail verdict with `midspan`=0 sets `det_done` with `det_good`=0. No further probing happens until `det_en` is lowered and raised again.
- R9: A fail verdict with `midspan`=1 removes the probe (`probe_code`=0) for exactly `BACKOFF_TICKS` ticks, after which a new attempt starts at `CODE_LO`.
- R10: `det_en` low returns the block to idle on the next clock edge from any state, with `probe_code`, `det_done` and `det_good` all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| det_en | input | 1 | Detection enable; rising starts, low aborts |
| midspan | input | 1 | Retry after back-off on a failed verdict |
| tick | input | 1 | Timebase tick, one cycle wide |
| smp_valid | input | 1 | ADC sample strobe |
| smp_v | input | SMP_W | Port voltage sample |
| smp_i | input | SMP_W | Probe current sample |
| verdict_valid | input | 1 | Classifier verdict strobe |
| verdict_pass | input | 1 | Classifier verdict, 1 = valid signature |
| pwr_on | output | 1 | Port power switch drive, held off |
| probe_code | output | CODE_W | Probe level to the source, 0 = probe off |
| meas_valid | output | 1 | One-cycle strobe: both points ready |
| v_lo | output | SMP_W | Average voltage, first point |
| i_lo | output | SMP_W | Average current, first point |
| v_hi | output | SMP_W | Average voltage, second point |
| i_hi | output | SMP_W | Average current, second point |
| det_done | output | 1 | Detection finished |
| det_good | output | 1 | Finished with a valid signature |

## Verification
The hardest case to reach from the ports is the exact boundary between settling and integration, because nothing on the ports shows when sampling begins. The bench drives full-scale poison samples with the strobe high throughout settling and during a strobe-low gap. It counts its own ticks from the cycle the probe code changes and starts real samples only after the last settling tick. Any sample taken one cycle too early or too late would then shift the scoreboard's averages or leave integration waiting for samples that never come. The midspan back-off gets the same tick-exact counting, from the verdict to the reappearance of the low probe code.

// File: rtl/poe_probe_seq.sv
module poe_probe_seq #(
  parameter int SMP_W = 12,
  parameter int LOG2_N = 10,
  parameter int CODE_W = 8,
  parameter logic [CODE_W-1:0] CODE_LO = 40,
  parameter logic [CODE_W-1:0] CODE_HI = 90,
  parameter int SETTLE_TICKS = 20,
  parameter int BACKOFF_TICKS = 2200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              det_en,
  input  logic              midspan,
  input  logic              tick,
  input  logic              smp_valid,
  input  logic [SMP_W-1:0]  smp_v,
  input  logic [SMP_W-1:0]  smp_i,
  input  logic              verdict_valid,
  input  logic              verdict_pass,
  output logic              pwr_on,
  output logic [CODE_W-1:0] probe_code,
  output logic              meas_valid,
  output logic [SMP_W-1:0]  v_lo,
  output logic [SMP_W-1:0]  i_lo,
  output logic [SMP_W-1:0]  v_hi,
  output logic [SMP_W-1:0]  i_hi,
  output logic              det_done,
  output logic              det_good
);
  localparam int ACC_W = SMP_W + LOG2_N;
  localparam int CMAX  = (SETTLE_TICKS > BACKOFF_TICKS) ? SETTLE_TICKS : BACKOFF_TICKS;
  localparam int CNT_W = $clog2(CMAX + 1);

  typedef enum logic [2:0] {S_IDLE, S_SETTLE, S_INTEG, S_WAITV, S_BACKOFF, S_DONE} st_t;

  st_t              st;
  logic             hi_pt;
  logic [CNT_W-1:0] cnt;
  logic [LOG2_N-1:0] scnt;
  logic [ACC_W-1:0] acc_v, acc_i;

  wire [ACC_W-1:0] sum_v = acc_v + ACC_W'(smp_v);
  wire [ACC_W-1:0] sum_i = acc_i + ACC_W'(smp_i);
  wire settle_end  = tick && (cnt == CNT_W'(SETTLE_TICKS - 1));
  wire backoff_end = tick && (cnt == CNT_W'(BACKOFF_TICKS - 1));

  assign pwr_on = 1'b0;
  assign probe_code = (st == S_SETTLE || st == S_INTEG) ? (hi_pt ? CODE_HI : CODE_LO) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      hi_pt <= 1'b0;
      cnt <= '0;
      scnt <= '0;
      acc_v <= '0;
      acc_i <= '0;
      meas_valid <= 1'b0;
      v_lo <= '0;
      i_lo <= '0;
      v_hi <= '0;
      i_hi <= '0;
      det_done <= 1'b0;
      det_good <= 1'b0;
    end else begin
      meas_valid <= 1'b0;
      if (!det_en) begin
        st <= S_IDLE;
        hi_pt <= 1'b0;
        det_done <= 1'b0;
        det_good <= 1'b0;
      end else begin
        case (st)
          S_IDLE: begin
            st <= S_SETTLE;
            hi_pt <= 1'b0;
            cnt <= '0;
          end
          S_SETTLE: if (tick) begin
            if (settle_end) begin
              st <= S_INTEG;
              cnt <= '0;
              scnt <= '0;
              acc_v <= '0;
              acc_i <= '0;
            end else cnt <= cnt + 1'b1;
          end
          S_INTEG: if (smp_valid) begin
            scnt <= scnt + 1'b1;
            acc_v <= sum_v;
            acc_i <= sum_i;
            if (&scnt) begin
              if (!hi_pt) begin
                v_lo <= sum_v[ACC_W-1:LOG2_N];
                i_lo <= sum_i[ACC_W-1:LOG2_N];
                hi_pt <= 1'b1;
                st <= S_SETTLE;
              end else begin
                v_hi <= sum_v[ACC_W-1:LOG2_N];
                i_hi <= sum_i[ACC_W-1:LOG2_N];
                meas_valid <= 1'b1;
                st <= S_WAITV;
              end
            end
          end
          S_WAITV: if (verdict_valid) begin
            if (verdict_pass) begin
              st <= S_DONE;
              det_done <= 1'b1;
              det_good <= 1'b1;
            end else if (midspan) begin
              st <= S_BACKOFF;
              cnt <= '0;
            end else begin
              st <= S_DONE;
              det_done <= 1'b1;
            end
          end
          S_BACKOFF: if (tick) begin
            if (backoff_end) begin
              st <= S_SETTLE;
              hi_pt <= 1'b0;
              cnt <= '0;
            end else cnt <= cnt + 1'b1;
          end
          default: st <= S_DONE;
        endcase
      end
    end
  end

  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !det_en |=> (st == S_IDLE && !det_done)); // R10
  AST_MEAS_PULSE: assert property (@(posedge clk) disable iff (!rst_n) meas_valid |=> !meas_valid); // R6
  AST_MEAS_FROM_INTEG: assert property (@(posedge clk) disable iff (!rst_n) $rose(meas_valid) |-> $past(st == S_INTEG && smp_valid)); // R5
  AST_SETTLE_FIRST: assert property (@(posedge clk) disable iff (!rst_n) $rose(st == S_INTEG) |-> $past(st == S_SETTLE && tick)); // R4
  AST_PROBE_STABLE: assert property (@(posedge clk) disable iff (!rst_n) (st == S_INTEG) |-> $stable(probe_code)); // R4
  AST_BACKOFF_MIDSPAN: assert property (@(posedge clk) disable iff (!rst_n) $rose(st == S_BACKOFF) |-> $past(midspan && verdict_valid && !verdict_pass)); // R9
  AST_BACKOFF_NO_PROBE: assert property (@(posedge clk) disable iff (!rst_n) (st == S_BACKOFF) |-> (probe_code == '0)); // R9
endmodule

// File: tb/poe_probe_seq_tb.sv
module poe_probe_seq_tb;
  localparam int SW = 10, LN = 3, N = 8, ST = 3, BO = 12;
  localparam logic [7:0] LO = 8'd40, HI = 8'd90;

  logic clk = 0, rst_n = 0, det_en = 0, midspan = 0, tick = 0;
  logic smp_valid = 0, verdict_valid = 0, verdict_pass = 0;
  logic [SW-1:0] smp_v = '0, smp_i = '0;
  logic pwr_on, meas_valid, det_done, det_good;
  logic [7:0] probe_code;
  logic [SW-1:0] v_lo, i_lo, v_hi, i_hi;

  poe_probe_seq #(.SMP_W(SW), .LOG2_N(LN), .SETTLE_TICKS(ST), .BACKOFF_TICKS(BO)) u_dut (
    .clk(clk), .rst_n(rst_n), .det_en(det_en), .midspan(midspan), .tick(tick),
    .smp_valid(smp_valid), .smp_v(smp_v), .smp_i(smp_i),
    .verdict_valid(verdict_valid), .verdict_pass(verdict_pass),
    .pwr_on(pwr_on), .probe_code(probe_code), .meas_valid(meas_valid),
    .v_lo(v_lo), .i_lo(i_lo), .v_hi(v_hi), .i_hi(i_hi),
    .det_done(det_done), .det_good(det_good));

  always #5 clk = ~clk;

  int tdiv = 0;
  always @(negedge clk) begin
    tick <= (tdiv == 3);
    tdiv <= (tdiv + 1) % 4;
  end

  typedef struct {int vl; int il; int vh; int ih;} exp_t;
  exp_t q[$];
  exp_t e;
  int bv[2][N];
  int bi[2][N];
  int n_chk = 0, n_fail = 0, meas_cnt = 0, pwr_bad = 0;

  task automatic chk(bit ok, string req, string what, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  // monitor: pops expected averages when the strobe appears
  initial forever begin
    @(posedge clk);
    #1;
    if (rst_n) begin
      if (pwr_on !== 1'b0) pwr_bad++;
      if (meas_valid) begin
        if (q.size() == 0) chk(0, "R6", "strobe with no expected item", 1, 0);
        else begin
          e = q.pop_front();
          chk(int'(v_lo) == e.vl, "R5", "v_lo average", v_lo, e.vl);
          chk(int'(i_lo) == e.il, "R5", "i_lo average", i_lo, e.il);
          chk(int'(v_hi) == e.vh, "R6", "v_hi average", v_hi, e.vh);
          chk(int'(i_hi) == e.ih, "R6", "i_hi average", i_hi, e.ih);
        end
        meas_cnt++;
      end
    end
  end

  task automatic fill(int mode);
    exp_t x;
    int sv[2];
    int si[2];
    for (int p = 0; p < 2; p++) begin
      sv[p] = 0; si[p] = 0;
      for (int k = 0; k < N; k++) begin
        bv[p][k] = (mode == 1) ? 1023 : (mode == 2) ? 0 : int'($urandom_range(0, 1023));
        bi[p][k] = (mode == 1) ? 1023 : (mode == 2) ? 0 : int'($urandom_range(0, 1023));
        sv[p] += bv[p][k];
        si[p] += bi[p][k];
      end
    end
    x.vl = sv[0] >> LN; x.il = si[0] >> LN; x.vh = sv[1] >> LN; x.ih = si[1] >> LN;
    q.push_back(x);
  endtask

  // R4: count settling ticks from the probe change, poison until then
  task automatic run_point(int p, logic [7:0] code, logic [SW-1:0] poison);
    int w = 0;
    int t = 0;
    while (probe_code != code && w < 400) begin step(); w++; end
    chk(probe_code == code, "R3", "probe level code", probe_code, code);
    while (t < ST && w < 400) begin step(); w++; if (tick) t++; end
    for (int k = 0; k < N; k++) begin
      if (k == 2) begin
        smp_valid = 0; smp_v = poison; smp_i = poison;
        step();
      end
      smp_valid = 1; smp_v = SW'(bv[p][k]); smp_i = SW'(bi[p][k]);
      step();
    end
    smp_v = poison; smp_i = poison;
  endtask

  task automatic attempt(int mode, bit raise);
    int m0 = meas_cnt;
    int w = 0;
    logic [SW-1:0] poison = (mode == 1) ? '0 : '1;
    fill(mode);
    smp_valid = 1; smp_v = poison; smp_i = poison;
    if (raise) begin
      det_en = 1;
      step();
      chk(probe_code == LO, "R2", "first probe starts at once", probe_code, LO);
    end
    run_point(0, LO, poison);
    run_point(1, HI, poison);
    while (meas_cnt == m0 && w < 50) begin step(); w++; end
    chk(meas_cnt == m0 + 1, "R6", "measurement strobe count", meas_cnt - m0, 1);
    smp_valid = 0;
  endtask

  task automatic verdict(bit pass);
    verdict_valid = 1; verdict_pass = pass;
    step();
    verdict_valid = 0;
  endtask

  initial begin
    int c;
    int w;
    repeat (4) step();
    chk(probe_code == 0, "R3", "probe off in reset", probe_code, 0);
    chk(pwr_on == 0, "R1", "switch off in reset", pwr_on, 0);
    chk(meas_valid == 0 && det_done == 0, "R10", "idle outputs in reset", det_done, 0);
    rst_n = 1;
    repeat (3) step();

    // pass, random data, not midspan
    attempt(0, 1);
    verdict(1);
    chk(det_done && det_good, "R7", "pass reported", det_good, 1);
    repeat (10) step();
    chk(det_done && det_good && probe_code == 0, "R7", "pass held, no probing", probe_code, 0);
    det_en = 0; step();
    chk(!det_done && !det_good && probe_code == 0, "R10", "disable clears result", det_done, 0);

    // fail, full scale data, not midspan
    attempt(1, 1);
    verdict(0);
    chk(det_done && !det_good, "R8", "fail reported", det_good, 0);
    c = 0;
    repeat (60) begin step(); if (probe_code != 0) c++; end
    chk(c == 0, "R8", "cycles probing after fail", c, 0);
    det_en = 0; step();

    // midspan fail then retry
    midspan = 1;
    attempt(2, 1);
    verdict(0);
    chk(probe_code == 0 && !det_done, "R9", "probe off in back-off", probe_code, 0);
    c = 0; w = 0;
    while (probe_code == 0 && w < 500) begin step(); w++; if (tick) c++; end
    chk(c == BO, "R9", "back-off ticks", c, BO);
    chk(probe_code == LO, "R9", "retry starts at low level", probe_code, LO);
    attempt(0, 0);
    verdict(1);
    chk(det_done && det_good, "R7", "pass after retry", det_good, 1);
    det_en = 0; step();
    midspan = 0;

    // abort while waiting for verdict
    attempt(0, 1);
    det_en = 0; step();
    chk(probe_code == 0 && !det_done, "R10", "abort in verdict wait", probe_code, 0);
    repeat (3) step();
    attempt(0, 1);
    verdict(1);
    chk(det_good, "R7", "pass after abort", det_good, 1);
    det_en = 0; step();

    // abort during settling
    det_en = 1; step(); step();
    chk(probe_code == LO, "R3", "settling at low level", probe_code, LO);
    det_en = 0; step();
    chk(probe_code == 0, "R10", "abort in settling", probe_code, 0);
    step();
    attempt(0, 1);
    verdict(0);
    chk(det_done && !det_good, "R8", "fail after abort", det_good, 0);
    det_en = 0; step();

    chk(pwr_bad == 0, "R1", "cycles with switch on", pwr_bad, 0);
    chk(q.size() == 0, "R6", "unmatched expected items", q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule